// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

This block gathers thirty-two level-sensitive request lines from peripheral blocks and pins and folds them into two processor interrupt outputs: a fast output and a normal one. Each line is enabled or masked on its own. A per-line steering bit sends it to either output. For each output, a separate encoder names the most urgent line that is pending at that moment.

The block keeps no pending state. A request exists only while its source drives the line high. Software clears the cause at the originating device, and a source that is left asserted is reported again. Urgency follows the line index, with line 0 the most urgent. The lowest eight lines also carry a programmable 3-bit rank, and any of them that is pending is served ahead of every higher line.

Software reaches the block through a small register port: a 3-bit address, a write strobe, a read strobe and 32-bit data in each direction.

Top module: `dual_intc`

## Requirements
- R1: After reset, the enable, steering and rank registers read zero, both interrupt outputs are low, and both winner registers read zero.
- R2: The raw register (address 0) reads the current level of the 32 request lines.
- R3: The normal-status register (address 3) reads raw AND enable AND NOT steer. The fast-status register (address 4) reads raw AND enable AND steer. A steering bit of 1 selects the fast output. Enable is at address 1 and steering at address 2.
- R4: `fiq_o` is high exactly one clock after any fast-status bit is set, and low one clock after none is set. `irq_o` behaves the same way for the normal status. Neither output latches a request.
- R5: For lines 8 to 31, the lowest pending index wins, and the winner register reads the index plus 1. The normal winner is at address 6 and the fast winner at address 7.
- R6: A winner register reads 0 when no line is pending for its output.
- R7: Among pending lines 0 to 7, the smaller 3-bit rank wins, and a tie goes to the lower index. The rank of line k sits in bits 3k+2:3k of the rank register at address 5.
- R8: A pending line among 0 to 7 outranks every pending line among 8 to 31, whatever its rank.
- R9: Writes to addresses 0, 3, 4, 6 and 7 change no register.
- R10: A read returns the addressed register on `rd_data_o` one clock after the read strobe is sampled. The value holds while no read is strobed. Rank bits 31:24 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Level request lines, bit 0 most urgent |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt output |
| irq_o | output | 1 | Normal interrupt output |

## Verification
The steering logic is tried with interleaved enable and steering masks over all lines high, which separates masking from routing. Single lines that rise and then fall show the one-cycle output latency and the absence of latching. For the encoders, sparse sets of upper lines probe index order. Mixed lower lines with equal and unequal ranks separate rank order from tie order. A low-urgency lower line set against an upper line confirms that the lower group always comes first. Writes to every read-only address, each followed by read-back, show those writes are ignored.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_RAW     = 3'd0,
        A_ENABLE  = 3'd1,
        A_STEER   = 3'd2,
        A_NRM_ST  = 3'd3,
        A_FST_ST  = 3'd4,
        A_RANK    = 3'd5,
        A_NRM_WIN = 3'd6,
        A_FST_WIN = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/dual_intc_regs.sv
module dual_intc_regs
    import dual_intc_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int PROG   = 8,
    parameter int RANK_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LINES-1:0]         wr_data_i,
    output logic [LINES-1:0]         enable_o,
    output logic [LINES-1:0]         steer_o,
    output logic [PROG*RANK_W-1:0]   rank_o
);
    localparam int RANK_BITS = PROG * RANK_W;

    logic [LINES-1:0]     enable_q;
    logic [LINES-1:0]     steer_q;
    logic [RANK_BITS-1:0] rank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            steer_q  <= '0;
            rank_q   <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                A_ENABLE: enable_q <= wr_data_i;
                A_STEER:  steer_q  <= wr_data_i;
                A_RANK:   rank_q   <= wr_data_i[RANK_BITS-1:0];
                default:  ;
            endcase
        end
    end

    assign enable_o = enable_q;
    assign steer_o  = steer_q;
    assign rank_o   = rank_q;

    // R9: a write aimed at a read-only address leaves every register unchanged
    p_ro_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i != A_ENABLE && addr_i != A_STEER && addr_i != A_RANK)
        |=> ($stable(enable_q) && $stable(steer_q) && $stable(rank_q)));

    // R1: with no write strobe, configuration holds
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(enable_q) && $stable(steer_q) && $stable(rank_q)));
endmodule

// File: rtl/dual_intc_prio_enc.sv
module dual_intc_prio_enc #(
    parameter int LINES  = 32,
    parameter int PROG   = 8,
    parameter int RANK_W = 3,
    parameter int IDX_W  = 6
) (
    input  logic [LINES-1:0]       pend_i,
    input  logic [PROG*RANK_W-1:0] rank_i,
    output logic [IDX_W-1:0]       win_o
);
    logic              found;
    logic [RANK_W-1:0] best_rank;
    logic [IDX_W-1:0]  best_idx;

    always_comb begin
        found     = 1'b0;
        best_rank = '0;
        best_idx  = '0;
        // programmable group: strict less-than keeps the lower index on a tie
        for (int i = 0; i < PROG; i++) begin
            if (pend_i[i] && (!found || rank_i[i*RANK_W +: RANK_W] < best_rank)) begin
                found     = 1'b1;
                best_rank = rank_i[i*RANK_W +: RANK_W];
                best_idx  = IDX_W'(i);
            end
        end
        // index-ordered group: scanned downward so the lowest index is kept
        if (!found) begin
            for (int i = LINES - 1; i >= PROG; i--) begin
                if (pend_i[i]) begin
                    found    = 1'b1;
                    best_idx = IDX_W'(i);
                end
            end
        end
        win_o = found ? best_idx + IDX_W'(1) : '0;
    end
endmodule

// File: rtl/dual_intc.sv
module dual_intc
    import dual_intc_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int PROG   = 8,
    parameter int RANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       irq_lines_i,
    input  logic [2:0]        addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    output logic              fiq_o,
    output logic              irq_o
);
    localparam int IDX_W     = $clog2(LINES + 1);
    localparam int RANK_BITS = PROG * RANK_W;
    localparam int N_OUT     = 2;   // 0 = normal, 1 = fast

    logic [LINES-1:0]     enable_w, steer_w;
    logic [RANK_BITS-1:0] rank_w;
    logic [LINES-1:0]     nrm_st, fst_st;
    logic [LINES-1:0]     pend_arr [N_OUT];
    logic [IDX_W-1:0]     win_arr  [N_OUT];
    logic                 fiq_q, irq_q;
    logic [31:0]          rd_q;

    dual_intc_regs #(.LINES(LINES), .PROG(PROG), .RANK_W(RANK_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .enable_o  (enable_w),
        .steer_o   (steer_w),
        .rank_o    (rank_w)
    );

    assign nrm_st      = irq_lines_i & enable_w & ~steer_w;
    assign fst_st      = irq_lines_i & enable_w &  steer_w;
    assign pend_arr[0] = nrm_st;
    assign pend_arr[1] = fst_st;

    for (genvar g = 0; g < N_OUT; g++) begin : g_enc
        dual_intc_prio_enc #(.LINES(LINES), .PROG(PROG), .RANK_W(RANK_W), .IDX_W(IDX_W)) i_enc (
            .pend_i (pend_arr[g]),
            .rank_i (rank_w),
            .win_o  (win_arr[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            fiq_q <= |fst_st;
            irq_q <= |nrm_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en_i) begin
            unique case (addr_i)
                A_RAW:     rd_q <= irq_lines_i;
                A_ENABLE:  rd_q <= enable_w;
                A_STEER:   rd_q <= steer_w;
                A_NRM_ST:  rd_q <= nrm_st;
                A_FST_ST:  rd_q <= fst_st;
                A_RANK:    rd_q <= 32'(rank_w);
                A_NRM_WIN: rd_q <= 32'(win_arr[0]);
                A_FST_WIN: rd_q <= 32'(win_arr[1]);
                default:   rd_q <= '0;
            endcase
        end
    end

    assign rd_data_o = rd_q;
    assign fiq_o     = fiq_q;
    assign irq_o     = irq_q;

    // R4: outputs follow enabled, steered lines with one cycle of delay
    p_fiq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_lines_i & enable_w & steer_w)) |=> fiq_o);
    p_fiq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(irq_lines_i & enable_w & steer_w)) |=> !fiq_o);
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_lines_i & enable_w & ~steer_w)) |=> irq_o);
    p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(irq_lines_i & enable_w & ~steer_w)) |=> !irq_o);

    // R6: a winner is reported only when something is pending
    p_win_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_st == '0) |-> (win_arr[0] == '0));
    // R5: a nonzero winner names a line that is pending
    p_win_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_arr[1] != '0) |-> fst_st[win_arr[1] - IDX_W'(1)]);
    // R8: any pending programmable line wins ahead of the index-ordered group
    p_prog_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|nrm_st[PROG-1:0]) |-> (win_arr[0] != '0 && win_arr[0] <= IDX_W'(PROG)));
    // R10: read data holds while no read is strobed
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/test_dual_intc.sv
module test_dual_intc;
    localparam logic [2:0] A_RAW = 3'd0, A_EN = 3'd1, A_SEL = 3'd2, A_NST = 3'd3,
                           A_FST = 3'd4, A_RNK = 3'd5, A_NWIN = 3'd6, A_FWIN = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dual_intc i_dual_intc (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_data_i(wdata),
        .rd_data_o(rdata), .fiq_o(fiq), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_lines(logic [31:0] v);
        @(negedge clk);
        lines = v;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 fiq", {31'b0, fiq}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        rd(A_EN, v);   chk("R1 enable", v, 0);
        rd(A_SEL, v);  chk("R1 steer", v, 0);
        rd(A_RNK, v);  chk("R1 rank", v, 0);
        rd(A_NWIN, v); chk("R1 normal winner", v, 0);
    endtask

    task automatic t_raw();
        logic [31:0] v;
        set_lines(32'hA5A5_0F0F);
        rd(A_RAW, v); chk("R2 raw", v, 32'hA5A5_0F0F);
        rd(A_NST, v); chk("R3 masked by zero enable", v, 0);
    endtask

    task automatic t_split();
        logic [31:0] v;
        wr(A_EN, 32'h00FF_FF00);
        wr(A_SEL, 32'h0F0F_0F0F);
        set_lines(32'hFFFF_FFFF);
        rd(A_NST, v); chk("R3 normal status", v, 32'h00F0_F000);
        rd(A_FST, v); chk("R3 fast status", v, 32'h000F_0F00);
    endtask

    task automatic t_outputs();
        wr(A_EN, 32'hFFFF_FFFF);
        wr(A_SEL, 32'h0000_0100);
        set_lines(0);
        @(negedge clk);
        chk("R4 both low", {30'b0, fiq, irq}, 0);
        set_lines(32'h0000_0100);
        #1 chk("R4 fast not yet", {31'b0, fiq}, 0);
        @(negedge clk);
        chk("R4 fast after one cycle", {30'b0, fiq, irq}, 32'd2);
        set_lines(0);
        @(negedge clk);
        chk("R4 fast drops, no latch", {30'b0, fiq, irq}, 0);
        set_lines(32'h0010_0000);
        @(negedge clk);
        chk("R4 normal raised", {30'b0, fiq, irq}, 32'd1);
    endtask

    task automatic t_index();
        logic [31:0] v;
        wr(A_SEL, 0);
        wr(A_RNK, 0);
        set_lines(32'h8002_0200);
        rd(A_NWIN, v); chk("R5 lowest upper index", v, 10);
        set_lines(32'h8000_0000);
        rd(A_NWIN, v); chk("R5 line 31", v, 32);
        rd(A_FWIN, v); chk("R6 fast empty", v, 0);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        set_lines(0);
        rd(A_NWIN, v); chk("R6 normal empty", v, 0);
        wr(A_EN, 0);
        set_lines(32'hFFFF_FFFF);
        rd(A_NWIN, v); chk("R6 all masked", v, 0);
        wr(A_EN, 32'hFFFF_FFFF);
    endtask

    task automatic t_rank();
        logic [31:0] v;
        // line0 rank 5, line3 rank 2, line6 rank 2, line7 rank 0
        wr(A_RNK, 32'd5 | (32'd2 << 9) | (32'd2 << 18));
        set_lines(32'h0000_0049);
        rd(A_NWIN, v); chk("R7 tie to lower index", v, 4);
        set_lines(32'h0000_00C9);
        rd(A_NWIN, v); chk("R7 smallest rank", v, 8);
        wr(A_SEL, 32'h0000_00FF);
        set_lines(32'h0000_0049);
        rd(A_FWIN, v); chk("R7 fast side", v, 4);
        rd(A_NWIN, v); chk("R7 normal side empty", v, 0);
        wr(A_SEL, 0);
    endtask

    task automatic t_outrank();
        logic [31:0] v;
        wr(A_RNK, 32'hFFFF_FFFF);
        rd(A_RNK, v); chk("R10 rank upper bits zero", v, 32'h00FF_FFFF);
        set_lines(32'h0000_0120);
        rd(A_NWIN, v); chk("R8 lower group first", v, 6);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(A_EN, 32'h1234_5678);
        wr(A_SEL, 32'h0000_00F0);
        wr(A_RNK, 32'h0000_0ABC);
        foreach (v[i]) if (i < 1) ;
        wr(A_RAW, 32'hFFFF_FFFF);
        wr(A_NST, 32'hFFFF_FFFF);
        wr(A_FST, 32'hFFFF_FFFF);
        wr(A_NWIN, 32'hFFFF_FFFF);
        wr(A_FWIN, 32'hFFFF_FFFF);
        rd(A_EN, v);  chk("R9 enable kept", v, 32'h1234_5678);
        rd(A_SEL, v); chk("R9 steer kept", v, 32'h0000_00F0);
        rd(A_RNK, v); chk("R9 rank kept", v, 32'h0000_0ABC);
        rd(A_RAW, v); chk("R9 raw still lines", v, 32'h0000_0120);
        @(negedge clk);
        chk("R10 read data holds", rdata, 32'h0000_0120);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw();
        t_split();
        t_outputs();
        t_index();
        t_empty();
        t_rank();
        t_outrank();
        t_readonly();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule